// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous SRAM that returns read data through a two-register pipeline and generates the addresses of a four-word burst on its own. Each word holds two 9-bit lanes. A lane is an 8-bit data byte plus one parity bit, and the parity bit is kept and returned exactly like the data bits. A burst starts on one of two address strobes. The processor strobe always opens with a read. The controller strobe opens with a read or a write, as the write controls decide on that clock.

After the first clock, the advance input steps a 2-bit counter through the low address bits in linear order, wrapping within the aligned group of four. When advance is low, the burst is suspended and the current address is accessed again. Three chip enables qualify the strobes, and only the primary one gates the processor strobe. Writes are masked per lane. The output enable acts combinationally on a drive flag, which stands in for tri-state pins. A sleep input quietly ends any burst while the memory keeps its contents.

Top module: `sbs_pipe_sram`

## Requirements
- R1: A word is 18 bits. Lane 0 is bits [8:0] and lane 1 is bits [17:9]. Bit 8 is the parity bit of lane 0 and bit 17 is the parity bit of lane 1. Both parity bits are written and read back like the data bits of their lane.
- R2: A strobe that is taken while any of cs_main, cs_aux_a or cs_aux_b is low ends the current burst. From the second clock after it, rdata_oe stays low until a new burst reads.
- R3: cpu_strobe is ignored while cs_main is low. A running burst then continues as if no strobe had been given.
- R4: A burst started by cpu_strobe performs a read on its first clock, whatever the write controls are. A write to the loaded address can happen on a later clock of the burst.
- R5: When cpu_strobe and ctl_strobe are both high and all chip enables are high, the processor strobe wins and the cycle is a read. No write takes place on that clock.
- R6: A burst started by ctl_strobe with all enables high reads or writes the loaded address on its first clock, as the write controls give.
- R7: On a burst clock with advance high, the access address is the previous one with its low two bits incremented modulo 4. The upper bits do not change (so 0x13 is followed by 0x10).
- R8: On a burst clock with advance low and no strobe taken, the same address is accessed again.
- R9: glob_we high writes both lanes. Otherwise lane_we_en high writes lane k when lane_sel[k] is high. lane_we_en with lane_sel = 00 is a read.
- R10: A read whose address is taken at clock edge E shows its data on rdata, with the rdata_oe flag, after edge E+1.
- R11: rdata_oe is high only while oe is high. It follows oe with no clock edge.
- R12: While sleep is high, all strobes and writes are ignored, the burst ends and rdata_oe is low from the first edge on. After sleep is released, rdata_oe stays low until a new read, and the stored words are unchanged.
- R13: After reset, no burst is active and rdata_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Address loaded by a taken strobe |
| cpu_strobe | input | 1 | Processor address strobe, read on first clock |
| ctl_strobe | input | 1 | Controller address strobe, read or write on first clock |
| cs_main | input | 1 | Primary chip enable, also gates cpu_strobe |
| cs_aux_a | input | 1 | Second chip enable |
| cs_aux_b | input | 1 | Third chip enable |
| advance | input | 1 | Step the burst counter on this clock |
| glob_we | input | 1 | Write both lanes |
| lane_we_en | input | 1 | Enable the per-lane write selects |
| lane_sel | input | LANES | Per-lane write select |
| wdata | input | LANES*LANE_W | Write data |
| oe | input | 1 | Output enable, combinational |
| sleep | input | 1 | Low-power request, ignores the interface |
| rdata | output | LANES*LANE_W | Read data |
| rdata_oe | output | 1 | High when rdata would be driven on the pins |

## Verification
A counter that steps wrongly or fails to hold shows up as wrong data in the read that follows. That error reaches rdata after two clock edges, because the pipeline adds one register after the address register. A wrong burst-active state or a missed deselect shows up as rdata_oe being high or low on the wrong clock. Because of this the bench compares the drive flag and the data against its own model on every cycle. Lane mask errors only show up on a later read of the same word, so the masking tests write a word, overwrite single lanes, and then read the word back through a second burst.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             sleep,
    input  logic             cs_main,
    input  logic             cs_aux_a,
    input  logic             cs_aux_b,
    input  logic             cpu_strobe,
    input  logic             ctl_strobe,
    input  logic             burst_on,
    input  logic             glob_we,
    input  logic             lane_we_en,
    input  logic [LANES-1:0] lane_sel,
    output op_e              op,
    output logic             load,
    output logic             drop,
    output logic [LANES-1:0] wmask
);
    logic             all_sel;
    logic             cpu_hit;
    logic [LANES-1:0] req_mask;
    logic             wants_wr;

    always_comb begin
        all_sel  = cs_main & cs_aux_a & cs_aux_b;
        cpu_hit  = cpu_strobe & cs_main;
        req_mask = glob_we ? {LANES{1'b1}} : (lane_we_en ? lane_sel : '0);
        wants_wr = |req_mask;
        op       = OP_IDLE;
        load     = 1'b0;
        drop     = 1'b0;
        if (sleep) begin
            drop = 1'b1;
        end else if (cpu_hit) begin
            // processor strobe: first clock is always a read
            if (all_sel) begin
                load = 1'b1;
                op   = OP_READ;
            end else begin
                drop = 1'b1;
            end
        end else if (ctl_strobe) begin
            if (all_sel) begin
                load = 1'b1;
                op   = wants_wr ? OP_WRITE : OP_READ;
            end else begin
                drop = 1'b1;
            end
        end else if (burst_on) begin
            op = wants_wr ? OP_WRITE : OP_READ;
        end
        wmask = (op == OP_WRITE) ? req_mask : '0;
    end
endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr #(
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              drop,
    input  logic              step,
    input  logic [ADDR_W-1:0] load_addr,
    output logic              burst_on,
    output logic [ADDR_W-1:0] op_addr
);
    typedef struct packed {
        logic              on;
        logic [ADDR_W-1:0] addr;
    } ctr_t;

    ctr_t             st_d, st_q;
    logic [CNT_W-1:0] low_q;

    assign low_q    = st_q.addr[CNT_W-1:0];
    assign burst_on = st_q.on;

    always_comb begin
        if (load) begin
            op_addr = load_addr;
        end else if (step) begin
            op_addr = {st_q.addr[ADDR_W-1:CNT_W], low_q + CNT_W'(1)};
        end else begin
            op_addr = st_q.addr;
        end
        st_d = st_q;
        if (drop) begin
            st_d.on = 1'b0;
        end else if (load) begin
            st_d.on   = 1'b1;
            st_d.addr = op_addr;
        end else if (st_q.on) begin
            st_d.addr = op_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: linear wrap on the low bits, upper bits untouched
    assert_linear_step_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q.on && !load && !drop && step) |=>
            ((st_q.addr[CNT_W-1:0] == CNT_W'($past(st_q.addr[CNT_W-1:0]) + 1'b1)) &&
             (st_q.addr[ADDR_W-1:CNT_W] == $past(st_q.addr[ADDR_W-1:CNT_W]))));

    // R8: suspended burst keeps its address
    assert_suspend_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.on && !load && !drop && !step) |=> $stable(st_q.addr));
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 9,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        wmask,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] out_q;

        always_ff @(posedge clk) begin
            if (wr_en && wmask[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
            if (rd_en) begin
                out_q <= mem[raddr];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = out_q;
    end
endmodule

// File: rtl/sbs_pipe_sram.sv
module sbs_pipe_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    cpu_strobe,
    input  logic                    ctl_strobe,
    input  logic                    cs_main,
    input  logic                    cs_aux_a,
    input  logic                    cs_aux_b,
    input  logic                    advance,
    input  logic                    glob_we,
    input  logic                    lane_we_en,
    input  logic [LANES-1:0]        lane_sel,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    localparam int WORD_W = LANES * LANE_W;
    localparam int CNT_W  = 2;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] raddr;
        logic              valid;
    } pipe_t;

    op_e               op;
    logic              load, drop, burst_on;
    logic [LANES-1:0]  wmask;
    logic [ADDR_W-1:0] op_addr;
    logic [WORD_W-1:0] arr_rdata;
    pipe_t             pipe_d, pipe_q;

    sbs_decode #(.LANES(LANES)) u_decode (
        .sleep      (sleep),
        .cs_main    (cs_main),
        .cs_aux_a   (cs_aux_a),
        .cs_aux_b   (cs_aux_b),
        .cpu_strobe (cpu_strobe),
        .ctl_strobe (ctl_strobe),
        .burst_on   (burst_on),
        .glob_we    (glob_we),
        .lane_we_en (lane_we_en),
        .lane_sel   (lane_sel),
        .op         (op),
        .load       (load),
        .drop       (drop),
        .wmask      (wmask)
    );

    sbs_burst_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .drop      (drop),
        .step      (advance),
        .load_addr (addr),
        .burst_on  (burst_on),
        .op_addr   (op_addr)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk   (clk),
        .wr_en (op == OP_WRITE),
        .wmask (wmask),
        .waddr (op_addr),
        .wdata (wdata),
        .rd_en (pipe_q.rd),
        .raddr (pipe_q.raddr),
        .rdata (arr_rdata)
    );

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.rd    = (op == OP_READ);
        pipe_d.raddr = op_addr;
        pipe_d.valid = pipe_q.rd & ~sleep;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign rdata    = arr_rdata;
    assign rdata_oe = oe & pipe_q.valid;

    // R4: a taken processor strobe never writes on its first clock
    assert_cpu_first_read_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_strobe && cs_main && !sleep) |-> (op != OP_WRITE));

    // R5: both strobes with full select resolve to a read
    assert_cpu_priority_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_strobe && ctl_strobe && cs_main && cs_aux_a && cs_aux_b && !sleep) |-> (op == OP_READ));

    // R2: a taken strobe with an inactive enable ends the burst
    assert_deselect_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_strobe && !(cs_main && cs_aux_a && cs_aux_b) && !(cpu_strobe && cs_main)) |=> !burst_on);

    // R12: sleep clears the burst and the output pipeline
    assert_sleep_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        sleep |=> (!pipe_q.valid && !burst_on));

    // R10: valid read data stems from a read two edges earlier
    assert_pipe_origin_R10: assert property (@(posedge clk) disable iff (rst)
        pipe_q.valid |-> $past(op == OP_READ, 2));
endmodule

// File: tb/tb_sbs_pipe_sram.sv
module tb_sbs_pipe_sram;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  addr = '0;
    logic        cpu_strobe = 0, ctl_strobe = 0;
    logic        cs_main = 1, cs_aux_a = 1, cs_aux_b = 1;
    logic        advance = 0, glob_we = 0, lane_we_en = 0;
    logic [1:0]  lane_sel = '0;
    logic [17:0] wdata = '0;
    logic        oe = 1, sleep = 0;
    logic [17:0] rdata;
    logic        rdata_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbs_pipe_sram dut (
        .clk(clk), .rst(rst), .addr(addr), .cpu_strobe(cpu_strobe), .ctl_strobe(ctl_strobe),
        .cs_main(cs_main), .cs_aux_a(cs_aux_a), .cs_aux_b(cs_aux_b), .advance(advance),
        .glob_we(glob_we), .lane_we_en(lane_we_en), .lane_sel(lane_sel), .wdata(wdata),
        .oe(oe), .sleep(sleep), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // behavioural reference model
    logic [17:0] mdl [int];
    bit          m_on = 0, m_rd = 0, m_rd_known = 0, m_valid = 0, m_known = 0;
    logic [8:0]  m_addr = '0;
    logic [17:0] m_snap = '0, m_data = '0;

    task automatic chk(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit all_sel, cpu_hit, ld, dr;
        int kind;
        logic [1:0]  mask;
        logic [8:0]  a;
        logic [17:0] w;
        if (rst) begin
            m_on = 0; m_rd = 0; m_valid = 0;
            return;
        end
        m_valid = m_rd && !sleep;
        if (m_rd) begin
            m_data  = m_snap;
            m_known = m_rd_known;
        end
        all_sel = cs_main && cs_aux_a && cs_aux_b;
        cpu_hit = cpu_strobe && cs_main;
        mask = glob_we ? 2'b11 : (lane_we_en ? lane_sel : 2'b00);
        kind = 0; ld = 0; dr = 0;
        if (sleep) dr = 1;
        else if (cpu_hit) begin
            if (all_sel) begin ld = 1; kind = 1; end else dr = 1;
        end else if (ctl_strobe) begin
            if (all_sel) begin ld = 1; kind = (mask != 0) ? 2 : 1; end else dr = 1;
        end else if (m_on) kind = (mask != 0) ? 2 : 1;
        if (ld) a = addr;
        else if (advance) a = {m_addr[8:2], m_addr[1:0] + 2'd1};
        else a = m_addr;
        if (dr) m_on = 0;
        else if (ld) begin m_on = 1; m_addr = a; end
        else if (m_on) m_addr = a;
        m_rd = (kind == 1);
        if (kind == 1) begin
            m_rd_known = mdl.exists(int'(a));
            m_snap = m_rd_known ? mdl[int'(a)] : '0;
        end
        if (kind == 2) begin
            w = mdl.exists(int'(a)) ? mdl[int'(a)] : '0;
            if (mask[0]) w[8:0]  = wdata[8:0];
            if (mask[1]) w[17:9] = wdata[17:9];
            mdl[int'(a)] = w;
        end
    endtask

    task automatic compare();
        bit exp_drv;
        exp_drv = oe && m_valid;
        chk(rdata_oe == exp_drv, "R11/R10 drive vs model", {17'b0, rdata_oe}, {17'b0, exp_drv});
        if (exp_drv && m_known)
            chk(rdata == m_data, "R10 data vs model", rdata, m_data);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic quiet();
        cpu_strobe = 0; ctl_strobe = 0; glob_we = 0; lane_we_en = 0; lane_sel = 2'b00;
        advance = 0; cs_main = 1; cs_aux_a = 1; cs_aux_b = 1; sleep = 0; oe = 1;
    endtask

    task automatic expect_word(input logic [17:0] exp, input string tag);
        chk(rdata_oe === 1'b1, tag, {17'b0, rdata_oe}, 18'd1);
        chk(rdata === exp, tag, rdata, exp);
    endtask

    localparam logic [17:0] D0 = 18'h10101, D1 = 18'h20202, D2 = 18'h30303, D3 = 18'h00404;
    localparam logic [17:0] V0 = 18'h3FFFF, W1 = 18'h00000, W2 = 18'h2AAAA;

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst = 0;
        tick();
        chk(rdata_oe == 1'b0, "R13 reset no drive", {17'b0, rdata_oe}, 18'd0);

        // burst write starting at 0x12 with wrap (R6 write first clock, R7)
        quiet(); addr = 9'h012; ctl_strobe = 1; glob_we = 1; wdata = D0; tick();
        ctl_strobe = 0; advance = 1; wdata = D1; tick();
        wdata = D2; tick();
        wdata = D3; tick();
        quiet(); ctl_strobe = 1; cs_aux_b = 0; tick();   // deselect
        quiet(); tick(); tick();

        // processor read burst at 0x10: suspend and wrap (R4 R10 R7 R8)
        addr = 9'h010; cpu_strobe = 1; tick();
        cpu_strobe = 0; advance = 1; tick(); expect_word(D2, "R10 first read data after second edge");
        tick(); expect_word(D3, "R7 second address");
        tick(); expect_word(D0, "R7 third address");
        advance = 0; tick(); expect_word(D1, "R7 fourth address");
        tick(); expect_word(D1, "R8 suspended address held");
        advance = 1; tick(); expect_word(D1, "R8 suspended read repeated");
        tick(); expect_word(D2, "R7 wrap to 0x10");
        oe = 0; #1;
        chk(rdata_oe == 1'b0, "R11 oe low releases drive", {17'b0, rdata_oe}, 18'd0);
        oe = 1; #1;
        chk(rdata_oe == 1'b1, "R11 oe high drives", {17'b0, rdata_oe}, 18'd1);

        // R3: cpu strobe ignored while cs_main low, burst continues
        cs_main = 0; cpu_strobe = 1; addr = 9'h1F0; tick();
        quiet(); tick(); expect_word(D0, "R3 burst continued past ignored strobe");
        quiet(); ctl_strobe = 1; cs_aux_a = 0; tick();
        quiet(); tick();
        chk(rdata_oe == 1'b0, "R2 ctl strobe with aux enable low deselects", {17'b0, rdata_oe}, 18'd0);

        // R4 / R9 / R1: lane masked writes
        addr = 9'h040; ctl_strobe = 1; glob_we = 1; wdata = V0; tick();
        quiet(); addr = 9'h040; cpu_strobe = 1; glob_we = 1; wdata = W1; tick();
        quiet(); lane_we_en = 1; lane_sel = 2'b01; wdata = W1; tick();
        expect_word(V0, "R4 first clock of cpu burst read old word");
        lane_sel = 2'b10; wdata = W2; tick();
        lane_sel = 2'b00; wdata = 18'h3FFFF; tick();
        quiet(); tick();
        expect_word({W2[17:9], 9'h000}, "R9 lane masks applied, empty select reads");
        chk(rdata[17] == 1'b1 && rdata[8] == 1'b0, "R1 parity bits per lane", rdata, {W2[17:9], 9'h000});

        // R5: both strobes, processor wins, no write
        quiet(); addr = 9'h040; cpu_strobe = 1; ctl_strobe = 1; glob_we = 1; wdata = V0; tick();
        quiet(); tick();
        expect_word({W2[17:9], 9'h000}, "R5 processor priority, no write");

        // R6: controller strobe read on first clock
        quiet(); addr = 9'h012; ctl_strobe = 1; tick();
        quiet(); tick(); expect_word(D0, "R6 controller strobe first clock read");

        // R2: cpu strobe with cs_aux_a low
        cpu_strobe = 1; cs_aux_a = 0; addr = 9'h010; tick();
        quiet(); tick();
        chk(rdata_oe == 1'b0, "R2 cpu strobe with aux enable low deselects", {17'b0, rdata_oe}, 18'd0);

        // R12: sleep
        quiet(); sleep = 1; tick();
        ctl_strobe = 1; glob_we = 1; addr = 9'h012; wdata = 18'h0; tick(); tick(); tick();
        chk(rdata_oe == 1'b0, "R12 no drive in sleep", {17'b0, rdata_oe}, 18'd0);
        quiet(); tick(); tick();
        chk(rdata_oe == 1'b0, "R12 still off after sleep exit", {17'b0, rdata_oe}, 18'd0);
        addr = 9'h012; ctl_strobe = 1; tick();
        quiet(); tick(); expect_word(D0, "R12 contents retained, write in sleep ignored");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R13: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule